// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the entry and return steps that a small 32-bit processor takes when its flow is broken by an event. Four event sources can request entry: a reset event, an address-translation miss, a general exception and an interrupt. The two exception sources share a 12-bit cause code input, and the interrupt source has its own 12-bit code input. The processor supplies its current program counter and status register. Software loads a vector base register through a simple write port.

When an event is taken, the block does four things in the same cycle. It computes the redirect address. It raises a status-register write strobe that carries the new status value. It records the interrupted PC and status word in shadow registers. It records the cause code in the exception or interrupt event register. Reset always goes to a fixed address. The other events go to a class-specific offset from the vector base.

A return request does the reverse. It redirects to the saved PC and writes the saved status word back. The status register itself lives outside the block and is updated from the write strobe.

Top module: `exc_entry_seq`

## Requirements
- R1: At most one action is taken per cycle. The priority order is reset event, translation miss, general exception, interrupt, return. `redirValid` and `srWe` are high together exactly when an action is taken.
- R2: While status bit 28 (the block bit) of `curSr` is 1, translation-miss, general-exception and interrupt requests are ignored. They cause no redirect and change no register. Reset and return requests are still taken.
- R3: On a translation miss, general exception or interrupt entry, `savedPc` and `savedSr` take `curPc` and `curSr` at the next clock edge.
- R4: On those same entries, `srWdata` equals `curSr` with bits 30 (privileged mode), 29 (register bank) and 28 (block) forced to 1. All other bits are unchanged.
- R5: A translation-miss or general-exception entry writes `excCode` into bits 11:0 of `expEvt`, with bits 31:12 cleared. `intEvt` is unchanged.
- R6: An interrupt entry writes `intCode` into bits 11:0 of `intEvt`, with bits 31:12 cleared. `expEvt` is unchanged.
- R7: A reset event redirects to 0xA0000000 whatever the vector base holds. It drives `srWdata` = 0x70000000, clears `vbr` at the next edge, and leaves the shadow and event registers unchanged.
- R8: A translation miss redirects to `vbr` + 0x400, a general exception to `vbr` + 0x100 and an interrupt to `vbr` + 0x600, all modulo 2^32.
- R9: A `vbrWe` pulse without a reset event loads `vbrWdata` into `vbr` at the next edge. An entry in the same cycle uses the old value.
- R10: A return redirects to `savedPc` and drives `srWdata` = `savedSr` in the same cycle.
- R11: While `rstN` is low, and after it is released, `savedPc`, `savedSr`, `expEvt`, `intEvt` and `vbr` read zero until they are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| rstReq | input | 1 | Reset event request |
| tlbReq | input | 1 | Translation-miss request |
| genReq | input | 1 | General exception request |
| intReq | input | 1 | Interrupt request |
| rteReq | input | 1 | Return-from-exception request |
| excCode | input | 12 | Cause code for translation-miss and general exceptions |
| intCode | input | 12 | Cause code for interrupts |
| curPc | input | 32 | Current program counter |
| curSr | input | 32 | Current status register |
| vbrWe | input | 1 | Vector base write enable |
| vbrWdata | input | 32 | Vector base write data |
| redirValid | output | 1 | Redirect taken this cycle |
| redirAddr | output | 32 | Redirect target address |
| srWe | output | 1 | Status register write strobe |
| srWdata | output | 32 | New status register value |
| savedPc | output | 32 | Shadow PC |
| savedSr | output | 32 | Shadow status register |
| expEvt | output | 32 | Exception event register |
| intEvt | output | 32 | Interrupt event register |
| vbr | output | 32 | Vector base register |

## Verification
The collision of interest is a vector base write landing in the same cycle as an entry that reads the vector base. The redirect must use the old base, and the new base must be visible from the next cycle. The bench provokes this twice on purpose: a write paired with an interrupt, and a write paired with a reset event, which must clear the base instead. Random traffic then fires `vbrWe` alongside requests in many more cycles. A behavioural model predicts the redirect address and the following register values, and the bench compares them against the design every cycle.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  parameter int XLEN      = 32;
  parameter int CODE_W    = 12;
  parameter int MODE_BIT  = 30;
  parameter int BANK_BIT  = 29;
  parameter int BLOCK_BIT = 28;

  parameter logic [XLEN-1:0] RST_VEC = 32'hA000_0000;
  parameter logic [XLEN-1:0] OFS_TLB = 32'h0000_0400;
  parameter logic [XLEN-1:0] OFS_GEN = 32'h0000_0100;
  parameter logic [XLEN-1:0] OFS_INT = 32'h0000_0600;

  localparam logic [XLEN-1:0] SR_ENTRY_SET =
    (XLEN'(1) << MODE_BIT) | (XLEN'(1) << BANK_BIT) | (XLEN'(1) << BLOCK_BIT);

  // One-hot action strobes from control to datapath
  typedef struct packed {
    logic takeRst;
    logic takeTlb;
    logic takeGen;
    logic takeInt;
    logic takeRte;
  } seq_strobe_t;
endpackage

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
  import exc_seq_pkg::*;
(
  input  logic        rstReq,
  input  logic        tlbReq,
  input  logic        genReq,
  input  logic        intReq,
  input  logic        rteReq,
  input  logic        blockBit,
  output seq_strobe_t strobe
);
  logic maskOk;

  assign maskOk = !blockBit;

  always_comb begin
    strobe = '0;
    if (rstReq)                 strobe.takeRst = 1'b1;
    else if (maskOk && tlbReq)  strobe.takeTlb = 1'b1;
    else if (maskOk && genReq)  strobe.takeGen = 1'b1;
    else if (maskOk && intReq)  strobe.takeInt = 1'b1;
    else if (rteReq)            strobe.takeRte = 1'b1;
  end
endmodule

// File: rtl/exc_seq_dp.sv
module exc_seq_dp
  import exc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strobe,
  input  logic [CODE_W-1:0] excCode,
  input  logic [CODE_W-1:0] intCode,
  input  logic [XLEN-1:0]   curPc,
  input  logic [XLEN-1:0]   curSr,
  input  logic              vbrWe,
  input  logic [XLEN-1:0]   vbrWdata,
  output logic              redirValid,
  output logic [XLEN-1:0]   redirAddr,
  output logic              srWe,
  output logic [XLEN-1:0]   srWdata,
  output logic [XLEN-1:0]   savedPc,
  output logic [XLEN-1:0]   savedSr,
  output logic [XLEN-1:0]   expEvt,
  output logic [XLEN-1:0]   intEvt,
  output logic [XLEN-1:0]   vbr
);
  localparam int PAD_W = XLEN - CODE_W;

  logic [XLEN-1:0] vbrQ, spcQ, ssrQ, expQ, intQ;
  logic            entryTaken;

  assign entryTaken = strobe.takeTlb | strobe.takeGen | strobe.takeInt;
  assign redirValid = |strobe;
  assign srWe       = redirValid;

  always_comb begin
    redirAddr = '0;
    srWdata   = curSr;
    if (strobe.takeRst) begin
      redirAddr = RST_VEC;
      srWdata   = SR_ENTRY_SET;
    end else if (strobe.takeTlb) begin
      redirAddr = vbrQ + OFS_TLB;
      srWdata   = curSr | SR_ENTRY_SET;
    end else if (strobe.takeGen) begin
      redirAddr = vbrQ + OFS_GEN;
      srWdata   = curSr | SR_ENTRY_SET;
    end else if (strobe.takeInt) begin
      redirAddr = vbrQ + OFS_INT;
      srWdata   = curSr | SR_ENTRY_SET;
    end else if (strobe.takeRte) begin
      redirAddr = spcQ;
      srWdata   = ssrQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vbrQ <= '0;
      spcQ <= '0;
      ssrQ <= '0;
      expQ <= '0;
      intQ <= '0;
    end else begin
      if (strobe.takeRst)  vbrQ <= '0;
      else if (vbrWe)      vbrQ <= vbrWdata;
      if (entryTaken) begin
        spcQ <= curPc;
        ssrQ <= curSr;
      end
      if (strobe.takeTlb || strobe.takeGen) expQ <= {{PAD_W{1'b0}}, excCode};
      if (strobe.takeInt)                   intQ <= {{PAD_W{1'b0}}, intCode};
    end
  end

  assign savedPc = spcQ;
  assign savedSr = ssrQ;
  assign expEvt  = expQ;
  assign intEvt  = intQ;
  assign vbr     = vbrQ;
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rstReq,
  input  logic              tlbReq,
  input  logic              genReq,
  input  logic              intReq,
  input  logic              rteReq,
  input  logic [CODE_W-1:0] excCode,
  input  logic [CODE_W-1:0] intCode,
  input  logic [XLEN-1:0]   curPc,
  input  logic [XLEN-1:0]   curSr,
  input  logic              vbrWe,
  input  logic [XLEN-1:0]   vbrWdata,
  output logic              redirValid,
  output logic [XLEN-1:0]   redirAddr,
  output logic              srWe,
  output logic [XLEN-1:0]   srWdata,
  output logic [XLEN-1:0]   savedPc,
  output logic [XLEN-1:0]   savedSr,
  output logic [XLEN-1:0]   expEvt,
  output logic [XLEN-1:0]   intEvt,
  output logic [XLEN-1:0]   vbr
);
  seq_strobe_t strobe;

  exc_seq_ctrl u_ctrl (
    .rstReq   (rstReq),
    .tlbReq   (tlbReq),
    .genReq   (genReq),
    .intReq   (intReq),
    .rteReq   (rteReq),
    .blockBit (curSr[BLOCK_BIT]),
    .strobe   (strobe)
  );

  exc_seq_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .excCode    (excCode),
    .intCode    (intCode),
    .curPc      (curPc),
    .curSr      (curSr),
    .vbrWe      (vbrWe),
    .vbrWdata   (vbrWdata),
    .redirValid (redirValid),
    .redirAddr  (redirAddr),
    .srWe       (srWe),
    .srWdata    (srWdata),
    .savedPc    (savedPc),
    .savedSr    (savedSr),
    .expEvt     (expEvt),
    .intEvt     (intEvt),
    .vbr        (vbr)
  );
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk
  import exc_seq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              rstReq,
  input logic              tlbReq,
  input logic              genReq,
  input logic              intReq,
  input logic              rteReq,
  input logic [CODE_W-1:0] excCode,
  input logic [CODE_W-1:0] intCode,
  input logic [XLEN-1:0]   curPc,
  input logic [XLEN-1:0]   curSr,
  input logic              vbrWe,
  input logic [XLEN-1:0]   vbrWdata,
  input logic              redirValid,
  input logic [XLEN-1:0]   redirAddr,
  input logic              srWe,
  input logic [XLEN-1:0]   srWdata,
  input logic [XLEN-1:0]   savedPc,
  input logic [XLEN-1:0]   savedSr,
  input logic [XLEN-1:0]   expEvt,
  input logic [XLEN-1:0]   intEvt,
  input logic [XLEN-1:0]   vbr
);
  localparam int PAD_W = XLEN - CODE_W;

  logic anyReq, blk, entryOk;
  assign anyReq  = rstReq | tlbReq | genReq | intReq | rteReq;
  assign blk     = curSr[BLOCK_BIT];
  assign entryOk = !rstReq && !blk && (tlbReq || genReq || intReq);

  // R1
  idle_no_redirect_chk: assert property (@(posedge clk) disable iff (!rstN)
    !anyReq |-> !redirValid && !srWe);

  // R1
  strobe_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    srWe == redirValid);

  // R2
  blocked_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (blk && !rstReq && !rteReq) |-> !redirValid);

  // R3
  shadow_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    entryOk |=> savedPc == $past(curPc) && savedSr == $past(curSr));

  // R4
  entry_sr_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    entryOk |-> srWdata == (curSr | SR_ENTRY_SET));

  // R5
  exp_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rstReq && !blk && (tlbReq || genReq)) |=> expEvt == {{PAD_W{1'b0}}, $past(excCode)});

  // R6
  int_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rstReq && !blk && !tlbReq && !genReq && intReq) |=> intEvt == {{PAD_W{1'b0}}, $past(intCode)});

  // R7
  reset_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> redirAddr == RST_VEC && srWdata == SR_ENTRY_SET);

  // R7
  reset_clears_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> vbr == '0);

  // R8
  int_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rstReq && !blk && !tlbReq && !genReq && intReq) |-> redirAddr == vbr + OFS_INT);

  // R9
  base_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vbrWe && !rstReq) |=> vbr == $past(vbrWdata));

  // R10
  return_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rteReq && !rstReq && (blk || !(tlbReq || genReq || intReq))) |->
      redirAddr == savedPc && srWdata == savedSr);
endmodule

bind exc_entry_seq exc_seq_chk u_chk (.*);

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rstReq = 0, tlbReq = 0, genReq = 0, intReq = 0, rteReq = 0;
  logic [11:0] excCode = '0, intCode = '0;
  logic [31:0] curPc = '0, curSr = '0;
  logic        vbrWe = 0;
  logic [31:0] vbrWdata = '0;
  logic        redirValid, srWe;
  logic [31:0] redirAddr, srWdata, savedPc, savedSr, expEvt, intEvt, vbr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural model state
  logic [31:0] mVbr = 0, mSpc = 0, mSsr = 0, mExp = 0, mInt = 0;
  logic [31:0] srReg = 0;

  exc_entry_seq dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare, advance model to post-edge state
  task automatic step(bit r, bit t, bit g, bit i, bit e, bit vw, logic [31:0] vd);
    int kind;
    logic [31:0] eAddr, eSr;
    bit blk;
    @(negedge clk);
    rstReq = r; tlbReq = t; genReq = g; intReq = i; rteReq = e;
    vbrWe = vw; vbrWdata = vd;
    curPc = $urandom; excCode = 12'($urandom); intCode = 12'($urandom);
    curSr = srReg;
    #1;
    blk = srReg[28];
    if (r) kind = 1;
    else if (!blk && t) kind = 2;
    else if (!blk && g) kind = 3;
    else if (!blk && i) kind = 4;
    else if (e) kind = 5;
    else kind = 0;
    eAddr = 0; eSr = srReg;
    case (kind)
      1: begin eAddr = 32'hA000_0000; eSr = 32'h7000_0000; end
      2: begin eAddr = mVbr + 32'h400; eSr = srReg | 32'h7000_0000; end
      3: begin eAddr = mVbr + 32'h100; eSr = srReg | 32'h7000_0000; end
      4: begin eAddr = mVbr + 32'h600; eSr = srReg | 32'h7000_0000; end
      5: begin eAddr = mSpc; eSr = mSsr; end
      default: ;
    endcase
    // registered state from the previous edge
    chk("R3 savedPc", savedPc, mSpc);
    chk("R3 savedSr", savedSr, mSsr);
    chk("R5 expEvt", expEvt, mExp);
    chk("R6 intEvt", intEvt, mInt);
    chk("R9 vbr", vbr, mVbr);
    // same-cycle outputs
    if (blk && (t || g || i) && !r && !e)
      chk("R2 blocked redirValid", 32'(redirValid), 32'(0));
    else
      chk("R1 redirValid", 32'(redirValid), 32'(kind != 0));
    chk("R1 srWe", 32'(srWe), 32'(kind != 0));
    if (kind != 0) begin
      case (kind)
        1: begin chk("R7 redirAddr", redirAddr, eAddr); chk("R7 srWdata", srWdata, eSr); end
        5: begin chk("R10 redirAddr", redirAddr, eAddr); chk("R10 srWdata", srWdata, eSr); end
        default: begin chk("R8 redirAddr", redirAddr, eAddr); chk("R4 srWdata", srWdata, eSr); end
      endcase
    end
    // model update for the coming edge
    if (kind == 1) mVbr = 0;
    else if (vw) mVbr = vd;
    if (kind >= 2 && kind <= 4) begin mSpc = curPc; mSsr = srReg; end
    if (kind == 2 || kind == 3) mExp = {20'b0, excCode};
    if (kind == 4) mInt = {20'b0, intCode};
    if (kind != 0) srReg = eSr;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R11: reset state held while rstN low
    chk("R11 savedPc", savedPc, 0);
    chk("R11 vbr", vbr, 0);
    chk("R11 expEvt", expEvt, 0);
    chk("R11 intEvt", intEvt, 0);
    chk("R11 savedSr", savedSr, 0);
    rstN = 1'b1;
    // idle cycle after release: R11 via model zero state
    step(0,0,0,0,0, 0, 0);
    // R9: load base, then interrupt in same cycle as another write (old base used)
    step(0,0,0,0,0, 1, 32'h8000_1000);
    step(0,0,0,1,0, 1, 32'h8000_2000);
    // R2: block bit now set; exceptions ignored
    step(0,1,1,1,0, 0, 0);
    // R10: return restores saved state (block bit clear again)
    step(0,0,0,0,1, 0, 0);
    // R1: all requests but reset, translation miss wins
    step(0,1,1,1,1, 0, 0);
    step(0,0,0,0,1, 0, 0);
    // R5: general exception
    step(0,0,1,1,0, 0, 0);
    step(0,0,0,0,1, 0, 0);
    // R7: reset event with simultaneous base write; base cleared
    step(1,1,1,1,1, 1, 32'h1234_5678);
    step(0,0,0,0,0, 0, 0);
    // R8: wrap-around of base + offset
    srReg = 32'h0000_00F0;
    step(0,0,0,0,0, 1, 32'hFFFF_FF00);
    step(0,1,0,0,0, 0, 0);
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 8 == 0) srReg = $urandom;
      step(($urandom % 50) == 0, ($urandom % 6) == 0, ($urandom % 6) == 0,
           ($urandom % 5) == 0, ($urandom % 5) == 0, ($urandom % 4) == 0, $urandom);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule